// File: doc/BRIEF.md
# Indirect PHY Delay Register Port

This block gives a host indirect access to a small bank of 8-bit PHY delay settings through a single 32-bit control word. Software stages a register address and a write byte in the word, then raises either the write strobe or the read strobe. The bridge notices the rising strobe and issues one transfer on an internal request/response interface to the delay bank. When the bank reports completion, the bridge raises an acknowledge flag. For a read, it also places the fetched byte in the word. The flag stays high until software drops the strobe that started the transfer, which closes a four-phase handshake.

The handshake controller has four named states:
- IDLE: waits for a rising strobe. IDLE goes to ISSUE on a rising edge of either strobe; the write strobe wins if both rise together.
- ISSUE: drives a one-cycle request to the bank and always goes to WAIT.
- WAIT: holds until the bank's completion pulse, then goes to ACKED.
- ACKED: keeps the acknowledge flag high and goes back to IDLE once the active strobe reads low.

A strobe edge seen outside IDLE is dropped and is not queued. The delay bank is a behavioural model with a parameterised response latency. It holds nine mode input delays at addresses 0x00 to 0x08 and three DLL delays at addresses 0x0B to 0x0D.

Top module: `phy_regport_bridge`

## Requirements
- R1: Control word layout: bit 26 is the acknowledge flag, bit 25 the read strobe, bit 24 the write strobe, bits 23:16 the read byte, bits 15:8 the write byte and bits 5:0 the PHY address. Bits 31:27 and 7:6 always read zero. Host writes to bit 26 and bits 23:16 have no effect. After reset the whole word reads zero.
- R2: A rising write strobe stores the staged write byte at the staged address. The acknowledge flag is raised only after the bank has reported completion.
- R3: A rising read strobe loads the addressed register into bits 23:16 no later than the cycle in which acknowledge rises. That byte does not change while acknowledge stays high.
- R4: Acknowledge stays high while the strobe that started the transfer is high. It reads low one cycle after the control word shows that strobe low.
- R5: A rising strobe seen while a transfer is in flight or acknowledge is high starts no transfer. It is also not remembered once acknowledge clears.
- R6: When both strobes rise in the same host write, a write transfer is performed and bits 23:16 keep their previous value.
- R7: Addresses 0x00 to 0x08 and 0x0B to 0x0D each hold an independent 8-bit value that reads back what was last written, and reset to zero.
- R8: Every other address reads as zero and ignores writes, but the transfer is still acknowledged.
- R9: Acknowledge first reads high exactly PHY_LAT + 3 cycles after the host write that raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Host write enable for the control word |
| ctl_wdata | input | 32 | Host write value for the control word |
| ctl_rdata | output | 32 | Current control word as seen by the host |

## Verification
Write-then-read pairs use distinct byte patterns (0x5A, 0xFF, 0x01, 0x80, 0xA5) across both delay groups. These show whether address decoding keeps neighbouring registers apart, and a stuck or swapped data bit shows up in a readback. Writes to the gaps at 0x09, 0x0A, 0x0E and 0x3F show aliasing onto implemented registers and whether acknowledge still arrives. A read strobe raised during an acknowledged write, and a dual-strobe raise, show whether edges are dropped and whether write priority holds. Counting poll cycles exposes an added or missing pipeline stage in the handshake.

// File: rtl/phy_regport_pkg.sv
package phy_regport_pkg;

    localparam int CW_W      = 32;
    localparam int PADDR_W   = 6;
    localparam int PDATA_W   = 8;

    localparam int ACK_BIT   = 26;
    localparam int RSTB_BIT  = 25;
    localparam int WSTB_BIT  = 24;
    localparam int RBYTE_LSB = 16;
    localparam int WBYTE_LSB = 8;
    localparam int ADDR_LSB  = 0;

    localparam int IN_DLY_LO  = 0;
    localparam int IN_DLY_HI  = 8;
    localparam int DLL_DLY_LO = 11;
    localparam int DLL_DLY_HI = 13;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_ACKED = 2'd3
    } hs_state_e;

    function automatic logic addr_present(input int a);
        return ((a >= IN_DLY_LO) && (a <= IN_DLY_HI)) ||
               ((a >= DLL_DLY_LO) && (a <= DLL_DLY_HI));
    endfunction

endpackage

// File: rtl/phy_regport_word.sv
module phy_regport_word
    import phy_regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [CW_W-1:0]    ctl_wdata,
    output logic [PADDR_W-1:0] addr_q,
    output logic [PDATA_W-1:0] wbyte_q,
    output logic               wstb_q,
    output logic               rstb_q,
    output logic               wstb_rise,
    output logic               rstb_rise
);

    logic wstb_prev;
    logic rstb_prev;
    logic unused_bits;

    assign unused_bits = ^{ctl_wdata[CW_W-1:WSTB_BIT+2],
                           ctl_wdata[RBYTE_LSB+PDATA_W-1:RBYTE_LSB],
                           ctl_wdata[WBYTE_LSB-1:ADDR_LSB+PADDR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wbyte_q <= '0;
            wstb_q  <= 1'b0;
            rstb_q  <= 1'b0;
        end else if (ctl_we) begin
            addr_q  <= ctl_wdata[ADDR_LSB +: PADDR_W];
            wbyte_q <= ctl_wdata[WBYTE_LSB +: PDATA_W];
            wstb_q  <= ctl_wdata[WSTB_BIT];
            rstb_q  <= ctl_wdata[RSTB_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstb_prev <= 1'b0;
            rstb_prev <= 1'b0;
        end else begin
            wstb_prev <= wstb_q;
            rstb_prev <= rstb_q;
        end
    end

    assign wstb_rise = wstb_q & ~wstb_prev;
    assign rstb_rise = rstb_q & ~rstb_prev;

endmodule

// File: rtl/phy_regport_fsm.sv
module phy_regport_fsm
    import phy_regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wstb_q,
    input  logic               rstb_q,
    input  logic               wstb_rise,
    input  logic               rstb_rise,
    input  logic [PADDR_W-1:0] addr_q,
    input  logic [PDATA_W-1:0] wbyte_q,
    input  logic               phy_done,
    input  logic [PDATA_W-1:0] phy_rbyte,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PADDR_W-1:0] phy_addr,
    output logic [PDATA_W-1:0] phy_wbyte,
    output logic               ack,
    output logic [PDATA_W-1:0] rbyte_q
);

    hs_state_e state_q, state_d;
    logic      op_write_q;
    logic      start;
    logic      active_lvl;

    assign start      = wstb_rise | rstb_rise;
    assign active_lvl = op_write_q ? wstb_q : rstb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)       state_d = S_ISSUE;
            S_ISSUE:                  state_d = S_WAIT;
            S_WAIT:  if (phy_done)    state_d = S_ACKED;
            S_ACKED: if (!active_lvl) state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            phy_addr   <= '0;
            phy_wbyte  <= '0;
            rbyte_q    <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                op_write_q <= wstb_rise;
                phy_addr   <= addr_q;
                phy_wbyte  <= wbyte_q;
            end
            if (state_q == S_WAIT && phy_done && !op_write_q)
                rbyte_q <= phy_rbyte;
        end
    end

    always_comb begin
        phy_req = (state_q == S_ISSUE);
        phy_we  = op_write_q;
        ack     = (state_q == S_ACKED);
    end

endmodule

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
    import phy_regport_pkg::*;
#(
    parameter int PHY_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [PADDR_W-1:0] addr,
    input  logic [PDATA_W-1:0] wbyte,
    output logic               done,
    output logic [PDATA_W-1:0] rbyte
);

    localparam int NREG  = 1 << PADDR_W;
    localparam int CNT_W = $clog2(PHY_LAT + 1);

    logic               pend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               we_q;
    logic [PADDR_W-1:0] addr_hold;
    logic [PDATA_W-1:0] wbyte_hold;
    logic               fire;
    logic [PDATA_W-1:0] view [NREG];

    assign fire = pend_q && (cnt_q == CNT_W'(PHY_LAT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            cnt_q      <= '0;
            we_q       <= 1'b0;
            addr_hold  <= '0;
            wbyte_hold <= '0;
            done       <= 1'b0;
            rbyte      <= '0;
        end else begin
            done <= 1'b0;
            if (req) begin
                pend_q     <= 1'b1;
                cnt_q      <= '0;
                we_q       <= we;
                addr_hold  <= addr;
                wbyte_hold <= wbyte;
            end else if (fire) begin
                pend_q <= 1'b0;
                done   <= 1'b1;
                rbyte  <= view[addr_hold];
            end else if (pend_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (addr_present(i)) begin : g_real
            logic [PDATA_W-1:0] val_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (fire && we_q && addr_hold == PADDR_W'(i))
                    val_q <= wbyte_hold;
            end
            assign view[i] = val_q;
        end else begin : g_hole
            assign view[i] = '0;
        end
    end

endmodule

// File: rtl/phy_regport_bridge.sv
module phy_regport_bridge
    import phy_regport_pkg::*;
#(
    parameter int PHY_LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [31:0]     ctl_wdata,
    output logic [31:0]     ctl_rdata
);

    logic [PADDR_W-1:0] addr_q;
    logic [PDATA_W-1:0] wbyte_q;
    logic               wstb_q, rstb_q;
    logic               wstb_rise, rstb_rise;
    logic               phy_req, phy_we, phy_done, ack;
    logic [PADDR_W-1:0] phy_addr;
    logic [PDATA_W-1:0] phy_wbyte, phy_rbyte, rbyte_q;

    phy_regport_word u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .addr_q    (addr_q),
        .wbyte_q   (wbyte_q),
        .wstb_q    (wstb_q),
        .rstb_q    (rstb_q),
        .wstb_rise (wstb_rise),
        .rstb_rise (rstb_rise)
    );

    phy_regport_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wstb_q    (wstb_q),
        .rstb_q    (rstb_q),
        .wstb_rise (wstb_rise),
        .rstb_rise (rstb_rise),
        .addr_q    (addr_q),
        .wbyte_q   (wbyte_q),
        .phy_done  (phy_done),
        .phy_rbyte (phy_rbyte),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wbyte (phy_wbyte),
        .ack       (ack),
        .rbyte_q   (rbyte_q)
    );

    phy_delay_bank #(.PHY_LAT(PHY_LAT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (phy_req),
        .we    (phy_we),
        .addr  (phy_addr),
        .wbyte (phy_wbyte),
        .done  (phy_done),
        .rbyte (phy_rbyte)
    );

    always_comb begin
        ctl_rdata                            = '0;
        ctl_rdata[ACK_BIT]                   = ack;
        ctl_rdata[RSTB_BIT]                  = rstb_q;
        ctl_rdata[WSTB_BIT]                  = wstb_q;
        ctl_rdata[RBYTE_LSB +: PDATA_W]      = rbyte_q;
        ctl_rdata[WBYTE_LSB +: PDATA_W]      = wbyte_q;
        ctl_rdata[ADDR_LSB +: PADDR_W]       = addr_q;
    end

endmodule

// File: rtl/phy_regport_chk.sv
module phy_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       wstb,
    input logic       rstb,
    input logic [7:0] rbyte,
    input logic       phy_req,
    input logic       phy_done
);

    // R2: acknowledge rises only right after a bank completion
    a_r2_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(phy_done));

    // R3: read byte frozen while acknowledge stays high
    a_r3_rbyte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(rbyte));

    // R4: acknowledge drops only after some strobe was low
    a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> (!$past(wstb) || !$past(rstb)));

    // R5: no bank request while acknowledge is high
    a_r5_no_req_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req |-> !ack);

    // R5: a request is a single-cycle pulse
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req |=> !phy_req);

endmodule

bind phy_regport_bridge phy_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .wstb     (wstb_q),
    .rstb     (rstb_q),
    .rbyte    (rbyte_q),
    .phy_req  (phy_req),
    .phy_done (phy_done)
);

// File: tb/phy_regport_bridge_tb.sv
module phy_regport_bridge_tb;

    localparam int PHY_LAT  = 3;
    localparam int MAX_POLL = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;

    int n_chk = 0;
    int n_bad = 0;

    phy_regport_bridge #(.PHY_LAT(PHY_LAT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic w, input logic r,
                                         input logic [7:0] d, input logic [5:0] a);
        return {5'b0, 1'b0, r, w, 8'h00, d, 2'b00, a};
    endfunction

    task automatic put(input logic [31:0] v);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic wait_ack(output int k);
        k = 0;
        while (!ctl_rdata[26] && k < MAX_POLL) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic xfer(input logic w, input logic r, input logic [5:0] a,
                        input logic [7:0] d, output int k, output logic [7:0] rb);
        put(word(1'b0, 1'b0, d, a));
        put(word(w, r, d, a));
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!ctl_rdata[26] && k < MAX_POLL);
        chk("R2 ack arrives", ctl_rdata[26], 1);
        rb = ctl_rdata[23:16];
        @(negedge clk);
        chk("R4 ack held while strobe high", ctl_rdata[26], 1);
        chk("R3 read byte stable during ack", ctl_rdata[23:16], rb);
        put(word(1'b0, 1'b0, d, a));
        @(negedge clk);
        chk("R4 ack low after strobe drop", ctl_rdata[26], 0);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        int k;
        logic [7:0] rb;
        xfer(1'b1, 1'b0, a, d, k, rb);
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
        int k;
        xfer(1'b0, 1'b1, a, 8'h00, k, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 word zero after reset", ctl_rdata, 0);
        rd_reg(6'h0D, v);
        chk("R7 reset value 0x0D", v, 0);
    endtask

    task automatic t_layout;
        put(32'hF8FF_FFFF);
        chk("R1 layout readback", ctl_rdata, 32'h0000_FF3F);
        put(word(1'b0, 1'b0, 8'hC3, 6'h2A));
        chk("R1 staged fields", ctl_rdata, 32'h0000_C32A);
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        wr_reg(6'h00, 8'h5A);
        wr_reg(6'h08, 8'hFF);
        wr_reg(6'h0B, 8'h01);
        wr_reg(6'h0D, 8'h80);
        wr_reg(6'h04, 8'hA5);
        rd_reg(6'h00, v); chk("R7 R2 addr 0x00", v, 8'h5A);
        rd_reg(6'h08, v); chk("R7 R2 addr 0x08", v, 8'hFF);
        rd_reg(6'h0B, v); chk("R7 R2 addr 0x0B", v, 8'h01);
        rd_reg(6'h0D, v); chk("R7 R2 addr 0x0D", v, 8'h80);
        rd_reg(6'h04, v); chk("R7 R2 addr 0x04", v, 8'hA5);
        rd_reg(6'h0C, v); chk("R7 untouched 0x0C", v, 8'h00);
        rd_reg(6'h03, v); chk("R3 read byte in word", ctl_rdata[23:16], 8'h00);
    endtask

    task automatic t_holes;
        logic [7:0] v;
        wr_reg(6'h09, 8'hAA);
        wr_reg(6'h0A, 8'h55);
        wr_reg(6'h0E, 8'h3C);
        wr_reg(6'h3F, 8'hC3);
        rd_reg(6'h09, v); chk("R8 hole 0x09 reads zero", v, 0);
        rd_reg(6'h3F, v); chk("R8 hole 0x3F reads zero", v, 0);
        rd_reg(6'h08, v); chk("R8 no alias onto 0x08", v, 8'hFF);
        rd_reg(6'h0D, v); chk("R8 no alias onto 0x0D", v, 8'h80);
    endtask

    task automatic t_latency;
        int k;
        logic [7:0] rb;
        xfer(1'b1, 1'b0, 6'h02, 8'h11, k, rb);
        chk("R9 write ack latency", k, PHY_LAT + 3);
        xfer(1'b0, 1'b1, 6'h02, 8'h00, k, rb);
        chk("R9 read ack latency", k, PHY_LAT + 3);
        chk("R3 read byte at ack", rb, 8'h11);
    endtask

    task automatic t_ignored_edge;
        int k;
        logic [7:0] v;
        int stray;
        rd_reg(6'h00, v);
        put(word(1'b0, 1'b0, 8'h33, 6'h0C));
        put(word(1'b1, 1'b0, 8'h33, 6'h0C));
        wait_ack(k);
        chk("R2 ack before stray edge", ctl_rdata[26], 1);
        put(word(1'b1, 1'b1, 8'h33, 6'h0C));
        put(word(1'b0, 1'b1, 8'h33, 6'h0C));
        @(negedge clk);
        chk("R4 ack drops with write strobe", ctl_rdata[26], 0);
        stray = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ctl_rdata[26]) stray++;
        end
        chk("R5 stray read edge starts nothing", stray, 0);
        chk("R5 read byte untouched", ctl_rdata[23:16], 8'h5A);
        put(word(1'b0, 1'b0, 8'h33, 6'h0C));
        rd_reg(6'h0C, v);
        chk("R5 write still landed", v, 8'h33);
    endtask

    task automatic t_both;
        int k;
        logic [7:0] rb;
        logic [7:0] v;
        xfer(1'b1, 1'b1, 6'h05, 8'h77, k, rb);
        chk("R6 dual strobe keeps read byte", rb, 8'h33);
        rd_reg(6'h05, v);
        chk("R6 dual strobe wrote", v, 8'h77);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_write_read();
        t_holes();
        t_latency();
        t_ignored_edge();
        t_both();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule